// File: doc/BRIEF.md
# Tiny 64-bit RISC Subset Core

This block is a multi-cycle processor core for a small subset of 64-bit RISC-V. It executes fourteen instructions: upper-immediate load, add-immediate, double-word load and store, add, subtract, multiply, unsigned divide and remainder, unsigned set-less-than, branch-if-equal, jump-and-link, register-indirect jump-and-link and the environment call. It holds a 64-bit program counter and thirty-two 64-bit general-purpose registers. All registers and the program counter are zero after reset.

Instructions and data share one memory port. That port moves aligned 64-bit double words through a request/acknowledge handshake. Each double word carries two instructions. The one at the lower byte address sits in bits 31:0, and program-counter bit 2 selects the half to run. An environment call stops the core and raises a request to an external responder. The request shows the service number and the three arguments. The core then waits for a done strobe and a 64-bit result.

An unknown instruction word, or a load or store whose address is not a multiple of 8, halts the core. The error output then stays set until reset.

Top module: `tiny_core`

## Requirements
- R1: Exactly the fourteen listed instructions run, with standard RISC-V encodings. Any other word, including any ecall variant other than 32'h00000073, sets `errOut`. `errOut` stays high until reset, and the core issues no further memory or ecall request.
- R2: Register 0 always reads as zero. Writes to register 0 are dropped.
- R3: Fetch reads the aligned double word that contains pc. It runs bits 31:0 when pc[2] is 0 and bits 63:32 when pc[2] is 1.
- R4: Every memory request has address bits 2:0 equal to zero. ld and sd use rs1 plus the sign-extended 12-bit immediate as the address. If that address is not 8-byte aligned, the core writes nothing, sets `errOut` and halts.
- R5: add, sub and addi wrap modulo 2^64. mul keeps the low 64 bits of the product. sltu compares unsigned and gives 1 or 0. lui gives the sign-extended imm20 shifted left by 12.
- R6: divu and remu treat both operands as unsigned. A zero divisor gives an all-ones quotient, and the remainder equals the dividend.
- R7: beq adds its signed, even 13-bit offset to pc when rs1 equals rs2. Otherwise pc advances by 4.
- R8: jal writes pc+4 to rd and adds its signed 21-bit offset to pc. jalr writes pc+4 to rd and jumps to (rs1+imm) with bit 0 cleared.
- R9: On ecall, `ecallReq` rises with `ecallNum` = x17 and `ecallArg0..2` = x10..x12. These hold stable until `ecallDone`. The core then writes `ecallResult` to x10, drops the request and continues at pc+4.
- R10: `memReq` stays high with a stable address, write-enable and write data until the cycle in which `memAck` is sampled. Load data is taken from `memRdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a store |
| memAddr | output | 64 | Double-word aligned byte address |
| memWdata | output | 64 | Store data |
| memRdata | input | 64 | Read data, valid with memAck |
| memAck | input | 1 | Memory completes the request this cycle |
| ecallReq | output | 1 | Environment call pending |
| ecallNum | output | 64 | Service number (x17) |
| ecallArg0 | output | 64 | First argument (x10) |
| ecallArg1 | output | 64 | Second argument (x11) |
| ecallArg2 | output | 64 | Third argument (x12) |
| ecallDone | input | 1 | Responder finished, result valid |
| ecallResult | input | 64 | Value written to x10 |
| errOut | output | 1 | Sticky error, core halted |

## Verification
Results become visible at different points, so the bench checks each one where it appears. A store appears in memory in the cycle its acknowledge is given. The ecall request rises one cycle after the instruction is decoded and falls on the clock edge that samples `ecallDone`. The responder therefore checks that the request is gone at the next falling edge. A divide or remainder takes about 66 cycles, and `errOut` rises one edge after the failing instruction is decoded. For these reasons the bench does not count cycles per instruction. Each test program stores its results and ends on an illegal word. The bench waits, with a cycle limit, for `errOut` and then compares memory with expected values computed by functions in the bench.

// File: rtl/tiny_core_pkg.sv
package tiny_core_pkg;

  typedef enum logic [3:0] {
    K_LUI, K_ADDI, K_LD, K_SD, K_ADD, K_SUB, K_MUL, K_DIVU,
    K_REMU, K_SLTU, K_BEQ, K_JAL, K_JALR, K_ECALL, K_BAD
  } instrKind_e;

  typedef enum logic [2:0] {
    WB_ALU, WB_MEM, WB_LINK, WB_DIV, WB_SYS
  } wbSel_e;

  typedef enum logic [1:0] {
    PC_STEP, PC_REL, PC_JALR
  } pcSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       irLoad;
    logic       regWe;
    wbSel_e     wbSel;
    logic       wbToA0;
    logic       pcLoad;
    pcSel_e     pcSel;
    logic       divStart;
    logic       memReq;
    logic       memWe;
    logic       useDataAddr;
  } ctrlStrobes_t;

  function automatic instrKind_e classifyWord(input logic [31:0] w);
    instrKind_e k;
    k = K_BAD;
    case (w[6:0])
      7'b0110111: k = K_LUI;
      7'b0010011: k = (w[14:12] == 3'd0) ? K_ADDI : K_BAD;
      7'b0000011: k = (w[14:12] == 3'd3) ? K_LD : K_BAD;
      7'b0100011: k = (w[14:12] == 3'd3) ? K_SD : K_BAD;
      7'b0110011: begin
        case ({w[31:25], w[14:12]})
          {7'h00, 3'd0}: k = K_ADD;
          {7'h20, 3'd0}: k = K_SUB;
          {7'h01, 3'd0}: k = K_MUL;
          {7'h01, 3'd5}: k = K_DIVU;
          {7'h01, 3'd7}: k = K_REMU;
          {7'h00, 3'd3}: k = K_SLTU;
          default:       k = K_BAD;
        endcase
      end
      7'b1100011: k = (w[14:12] == 3'd0) ? K_BEQ : K_BAD;
      7'b1101111: k = K_JAL;
      7'b1100111: k = (w[14:12] == 3'd0) ? K_JALR : K_BAD;
      7'b1110011: k = (w == 32'h0000_0073) ? K_ECALL : K_BAD;
      default:    k = K_BAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/core_divu.sv
module core_divu #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  remR, quoR, denR;
  logic [CW-1:0] stepCnt;
  logic          busy;
  logic [W:0]    trial, diff;
  logic          fits;

  // restoring division: a zero divisor naturally yields all-ones and the dividend
  assign trial = {remR, quoR[W-1]};
  assign diff  = trial - {1'b0, denR};
  assign fits  = ~diff[W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR    <= '0;
      quoR    <= '0;
      denR    <= '0;
      stepCnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      remR    <= '0;
      quoR    <= dividend;
      denR    <= divisor;
      stepCnt <= CW'(W - 1);
      busy    <= 1'b1;
      done    <= 1'b0;
    end else if (busy) begin
      remR <= fits ? diff[W-1:0] : trial[W-1:0];
      quoR <= {quoR[W-2:0], fits};
      if (stepCnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        stepCnt <= stepCnt - 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient  = quoR;
  assign remainder = remR;
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import tiny_core_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [31:0]  instrWord,
  input  logic         regsEqual,
  input  logic         dataMisaligned,
  input  logic         divDone,
  input  logic         memAck,
  input  logic         ecallDone,
  output instrKind_e   kind,
  output ctrlStrobes_t strobes,
  output logic         ecallReq,
  output logic         errOut
);
  typedef enum logic [2:0] {
    S_FETCH, S_EXEC, S_LOAD, S_STORE, S_DIV, S_SYS, S_HALT
  } phase_e;

  phase_e phase, phaseNext;

  assign kind = classifyWord(instrWord);

  always_ff @(posedge clk) begin
    if (!rstN) phase <= S_FETCH;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    case (phase)
      S_FETCH: begin
        strobes.memReq = 1'b1;
        if (memAck) begin
          strobes.irLoad = 1'b1;
          phaseNext      = S_EXEC;
        end
      end
      S_EXEC: begin
        phaseNext = S_FETCH;
        case (kind)
          K_LUI, K_ADDI, K_ADD, K_SUB, K_MUL, K_SLTU: begin
            strobes.regWe  = 1'b1;
            strobes.wbSel  = WB_ALU;
            strobes.pcLoad = 1'b1;
            strobes.pcSel  = PC_STEP;
          end
          K_LD:  phaseNext = dataMisaligned ? S_HALT : S_LOAD;
          K_SD:  phaseNext = dataMisaligned ? S_HALT : S_STORE;
          K_DIVU, K_REMU: begin
            strobes.divStart = 1'b1;
            phaseNext        = S_DIV;
          end
          K_BEQ: begin
            strobes.pcLoad = 1'b1;
            strobes.pcSel  = regsEqual ? PC_REL : PC_STEP;
          end
          K_JAL: begin
            strobes.regWe  = 1'b1;
            strobes.wbSel  = WB_LINK;
            strobes.pcLoad = 1'b1;
            strobes.pcSel  = PC_REL;
          end
          K_JALR: begin
            strobes.regWe  = 1'b1;
            strobes.wbSel  = WB_LINK;
            strobes.pcLoad = 1'b1;
            strobes.pcSel  = PC_JALR;
          end
          K_ECALL: phaseNext = S_SYS;
          default: phaseNext = S_HALT;
        endcase
      end
      S_LOAD: begin
        strobes.memReq      = 1'b1;
        strobes.useDataAddr = 1'b1;
        if (memAck) begin
          strobes.regWe  = 1'b1;
          strobes.wbSel  = WB_MEM;
          strobes.pcLoad = 1'b1;
          phaseNext      = S_FETCH;
        end
      end
      S_STORE: begin
        strobes.memReq      = 1'b1;
        strobes.memWe       = 1'b1;
        strobes.useDataAddr = 1'b1;
        if (memAck) begin
          strobes.pcLoad = 1'b1;
          phaseNext      = S_FETCH;
        end
      end
      S_DIV: begin
        if (divDone) begin
          strobes.regWe  = 1'b1;
          strobes.wbSel  = WB_DIV;
          strobes.pcLoad = 1'b1;
          phaseNext      = S_FETCH;
        end
      end
      S_SYS: begin
        if (ecallDone) begin
          strobes.regWe  = 1'b1;
          strobes.wbSel  = WB_SYS;
          strobes.wbToA0 = 1'b1;
          strobes.pcLoad = 1'b1;
          phaseNext      = S_FETCH;
        end
      end
      default: phaseNext = S_HALT;
    endcase
  end

  assign ecallReq = (phase == S_SYS);
  assign errOut   = (phase == S_HALT);
endmodule

// File: rtl/core_dpath.sv
module core_dpath
  import tiny_core_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  instrKind_e      kind,
  output logic [31:0]     instrWord,
  output logic            regsEqual,
  output logic            dataMisaligned,
  output logic            divDone,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] ecallNum,
  output logic [XLEN-1:0] ecallArg0,
  output logic [XLEN-1:0] ecallArg1,
  output logic [XLEN-1:0] ecallArg2,
  input  logic [XLEN-1:0] ecallResult
);
  localparam int RW = $clog2(NREGS);
  localparam int ALIGN = 3;
  localparam logic [RW-1:0] A0_IDX = RW'(10);
  localparam logic [RW-1:0] A7_IDX = RW'(17);

  logic [XLEN-1:0] regs [NREGS];
  logic [XLEN-1:0] pc;
  logic [31:0]     ir;
  logic [RW-1:0]   rdIdx, rs1Idx, rs2Idx, wbAddr;
  logic [XLEN-1:0] rs1v, rs2v;
  logic [XLEN-1:0] immI, immS, immB, immJ, immU;
  logic [XLEN-1:0] aluB, aluRes, dataAddr, pcPlus4, relTarget, jalrSum;
  logic [XLEN-1:0] quo, rem, wbData, pcNext;

  assign rdIdx  = ir[11:7];
  assign rs1Idx = ir[19:15];
  assign rs2Idx = ir[24:20];

  assign rs1v = (rs1Idx == '0) ? '0 : regs[rs1Idx];
  assign rs2v = (rs2Idx == '0) ? '0 : regs[rs2Idx];

  assign immI = {{(XLEN-12){ir[31]}}, ir[31:20]};
  assign immS = {{(XLEN-12){ir[31]}}, ir[31:25], ir[11:7]};
  assign immB = {{(XLEN-13){ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
  assign immJ = {{(XLEN-21){ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
  assign immU = {{(XLEN-32){ir[31]}}, ir[31:12], 12'b0};

  assign aluB = (kind == K_ADDI) ? immI : rs2v;

  always_comb begin
    case (kind)
      K_ADD, K_ADDI: aluRes = rs1v + aluB;
      K_SUB:         aluRes = rs1v - rs2v;
      K_MUL:         aluRes = rs1v * rs2v;
      K_SLTU:        aluRes = {{(XLEN-1){1'b0}}, (rs1v < rs2v)};
      K_LUI:         aluRes = immU;
      default:       aluRes = '0;
    endcase
  end

  core_divu #(.W(XLEN)) u_divu (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strobes.divStart),
    .dividend (rs1v),
    .divisor  (rs2v),
    .quotient (quo),
    .remainder(rem),
    .done     (divDone)
  );

  assign dataAddr       = rs1v + ((kind == K_SD) ? immS : immI);
  assign dataMisaligned = |dataAddr[ALIGN-1:0];
  assign regsEqual      = (rs1v == rs2v);

  assign memAddr  = strobes.useDataAddr ? {dataAddr[XLEN-1:ALIGN], {ALIGN{1'b0}}}
                                        : {pc[XLEN-1:ALIGN], {ALIGN{1'b0}}};
  assign memWdata = rs2v;

  assign pcPlus4   = pc + XLEN'(4);
  assign relTarget = pc + ((kind == K_JAL) ? immJ : immB);
  assign jalrSum   = rs1v + immI;

  always_comb begin
    case (strobes.pcSel)
      PC_REL:  pcNext = relTarget;
      PC_JALR: pcNext = {jalrSum[XLEN-1:1], 1'b0};
      default: pcNext = pcPlus4;
    endcase
  end

  always_comb begin
    case (strobes.wbSel)
      WB_MEM:  wbData = memRdata;
      WB_LINK: wbData = pcPlus4;
      WB_DIV:  wbData = (kind == K_REMU) ? rem : quo;
      WB_SYS:  wbData = ecallResult;
      default: wbData = aluRes;
    endcase
  end

  assign wbAddr = strobes.wbToA0 ? A0_IDX : rdIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
      ir <= '0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (strobes.irLoad) ir <= pc[2] ? memRdata[63:32] : memRdata[31:0];
      if (strobes.pcLoad) pc <= pcNext;
      if (strobes.regWe && wbAddr != '0) regs[wbAddr] <= wbData;
    end
  end

  assign instrWord = ir;
  assign ecallNum  = regs[A7_IDX];
  assign ecallArg0 = regs[A0_IDX];
  assign ecallArg1 = regs[A0_IDX + RW'(1)];
  assign ecallArg2 = regs[A0_IDX + RW'(2)];
endmodule

// File: rtl/tiny_core.sv
module tiny_core
  import tiny_core_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  input  logic            memAck,
  output logic            ecallReq,
  output logic [XLEN-1:0] ecallNum,
  output logic [XLEN-1:0] ecallArg0,
  output logic [XLEN-1:0] ecallArg1,
  output logic [XLEN-1:0] ecallArg2,
  input  logic            ecallDone,
  input  logic [XLEN-1:0] ecallResult,
  output logic            errOut
);
  ctrlStrobes_t strobes;
  instrKind_e   kind;
  logic [31:0]  instrWord;
  logic         regsEqual, dataMisaligned, divDone;

  core_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .instrWord     (instrWord),
    .regsEqual     (regsEqual),
    .dataMisaligned(dataMisaligned),
    .divDone       (divDone),
    .memAck        (memAck),
    .ecallDone     (ecallDone),
    .kind          (kind),
    .strobes       (strobes),
    .ecallReq      (ecallReq),
    .errOut        (errOut)
  );

  core_dpath #(.XLEN(XLEN), .NREGS(NREGS)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .kind          (kind),
    .instrWord     (instrWord),
    .regsEqual     (regsEqual),
    .dataMisaligned(dataMisaligned),
    .divDone       (divDone),
    .memAddr       (memAddr),
    .memWdata      (memWdata),
    .memRdata      (memRdata),
    .ecallNum      (ecallNum),
    .ecallArg0     (ecallArg0),
    .ecallArg1     (ecallArg1),
    .ecallArg2     (ecallArg2),
    .ecallResult   (ecallResult)
  );

  assign memReq = strobes.memReq;
  assign memWe  = strobes.memWe;
endmodule

// File: rtl/tiny_core_checks.sv
module tiny_core_checks #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            memReq,
  input logic            memWe,
  input logic [XLEN-1:0] memAddr,
  input logic [XLEN-1:0] memWdata,
  input logic            memAck,
  input logic            ecallReq,
  input logic            ecallDone,
  input logic [XLEN-1:0] ecallNum,
  input logic [XLEN-1:0] ecallArg0,
  input logic            errOut
);
  p_err_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    errOut |=> errOut);

  p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (!memReq && !ecallReq));

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[2:0] == 3'b000));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)
                             && $stable(memWdata)));

  p_sys_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ecallReq && !ecallDone) |=> (ecallReq && $stable(ecallNum) && $stable(ecallArg0)));

  p_sys_alone_r9: assert property (@(posedge clk) disable iff (!rstN)
    ecallReq |-> !memReq);
endmodule

bind tiny_core tiny_core_checks #(.XLEN(XLEN)) u_checks (.*);

// File: tb/sim_tiny_core.sv
module sim_tiny_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [63:0] memAddr, memWdata, memRdata = '0;
  logic        ecallReq, ecallDone = 1'b0, errOut;
  logic [63:0] ecallNum, ecallArg0, ecallArg1, ecallArg2, ecallResult = '0;

  logic [63:0] mem [MEM_WORDS];
  int checks = 0, fails = 0;
  int wp;
  int ecallSeen, ecallWait;
  logic [63:0] curA, sysRet;
  logic sysExpected;

  tiny_core u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // memory model: acknowledges one falling edge after a request appears
  always @(negedge clk) begin
    if (memReq && !memAck && rstN) begin
      memAck   = 1'b1;
      memRdata = mem[int'(memAddr[11:3])];
      if (memWe) mem[int'(memAddr[11:3])] = memWdata;
    end else begin
      memAck = 1'b0;
    end
  end

  // ecall responder with a three-cycle delay
  always @(negedge clk) begin
    if (ecallDone) begin
      ecallDone = 1'b0;
      check("R9 request drops after done", {63'b0, ecallReq}, 64'd0);
    end else if (ecallReq && rstN) begin
      ecallWait++;
      if (ecallWait == 3) begin
        ecallWait = 0;
        ecallSeen++;
        check("R1 ecall allowed here", {63'b0, sysExpected}, 64'd1);
        check("R9 service number", ecallNum, 64'd63);
        check("R9 argument a0", ecallArg0, curA);
        ecallResult = sysRet;
        ecallDone   = 1'b1;
      end
    end
  end

  function automatic logic [31:0] encR(input int f7, input int rs2, input int rs1, input int f3, input int rd);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] encI(input int imm, input int rs1, input int f3, input int rd, input logic [6:0] op);
    return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] encS(input int imm, input int rs2, input int rs1);
    logic [11:0] o = 12'(imm);
    return {o[11:5], 5'(rs2), 5'(rs1), 3'b011, o[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] encB(input int off, input int rs1, input int rs2);
    logic [12:0] o = 13'(off);
    return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'b000, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] encJ(input int off, input int rd);
    logic [20:0] o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], 5'(rd), 7'b1101111};
  endfunction

  function automatic logic [63:0] expDivu(input logic [63:0] a, input logic [63:0] b);
    return (b == 0) ? {64{1'b1}} : a / b;
  endfunction
  function automatic logic [63:0] expRemu(input logic [63:0] a, input logic [63:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic put(input logic [31:0] w);
    if (wp[0]) mem[wp >> 1][63:32] = w;
    else       mem[wp >> 1][31:0]  = w;
    wp++;
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    wp = 0;
  endtask

  // reset, release, then wait for the halt; the limit acts as the watchdog
  task automatic runUntilHalt(input string tag);
    int n;
    rstN = 1'b0;
    ecallWait = 0;
    repeat (3) @(negedge clk);
    check("R1 reset clears error", {63'b0, errOut}, 64'd0);
    check("R9 reset clears ecall request", {63'b0, ecallReq}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 first fetch at address 0", memAddr, 64'd0);
    n = 0;
    while (!errOut && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!errOut) begin
      checks++;
      fails++;
      $display("FAIL watchdog %s: got no halt expected halt", tag);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R1 halted core stays quiet", {62'b0, memReq, ecallReq}, 64'd0);
      check("R1 error sticky", {63'b0, errOut}, 64'd1);
    end
  endtask

  task automatic mainRound(input logic [63:0] a, input logic [63:0] b);
    clearMem();
    mem[128] = a;
    mem[129] = b;
    curA = a;
    sysRet = {$urandom, $urandom};
    sysExpected = 1'b1;
    ecallSeen = 0;
    put(encI(12'h400, 0, 3, 5, 7'b0000011));
    put(encI(12'h408, 0, 3, 6, 7'b0000011));
    put(encR(0, 6, 5, 0, 7));      put(encS(12'h410, 7, 0));
    put(encR(32, 6, 5, 0, 7));     put(encS(12'h418, 7, 0));
    put(encR(1, 6, 5, 0, 7));      put(encS(12'h420, 7, 0));
    put(encR(0, 6, 5, 3, 7));      put(encS(12'h428, 7, 0));
    put(encR(1, 6, 5, 5, 7));      put(encS(12'h430, 7, 0));
    put(encR(1, 6, 5, 7, 7));      put(encS(12'h438, 7, 0));
    put(encI(-5, 5, 0, 8, 7'b0010011));   put(encS(12'h440, 8, 0));
    put({20'h80001, 5'd9, 7'b0110111});   put(encS(12'h448, 9, 0));
    put(encI(1, 5, 0, 0, 7'b0010011));    put(encS(12'h450, 0, 0));
    put(encI(7, 0, 0, 10, 7'b0010011));   put(encB(8, 5, 6));
    put(encI(3, 0, 0, 10, 7'b0010011));   put(encS(12'h458, 10, 0));
    put(encJ(8, 11));                      put(encI(9, 0, 0, 12, 7'b0010011));
    put(encS(12'h460, 11, 0));             put(encS(12'h468, 12, 0));
    put(encI(125, 0, 0, 13, 7'b0010011)); put(encI(0, 13, 0, 14, 7'b1100111));
    put(encI(5, 0, 0, 15, 7'b0010011));   put(encS(12'h470, 14, 0));
    put(encS(12'h478, 15, 0));
    put(encI(63, 0, 0, 17, 7'b0010011));  put(encI(0, 5, 0, 10, 7'b0010011));
    put(32'h0000_0073);                    put(encS(12'h480, 10, 0));
    put(32'hFFFF_FFFF);
    runUntilHalt("main");
    check("R5 add",  mem[130], a + b);
    check("R5 sub",  mem[131], a - b);
    check("R5 mul low half", mem[132], a * b);
    check("R5 sltu unsigned", mem[133], {63'b0, (a < b)});
    check("R6 divu", mem[134], expDivu(a, b));
    check("R6 remu", mem[135], expRemu(a, b));
    check("R5 addi negative", mem[136], a - 64'd5);
    check("R5 lui sign extend", mem[137], 64'hFFFF_FFFF_8000_1000);
    check("R2 x0 stays zero", mem[138], 64'd0);
    check("R7 beq", mem[139], (a == b) ? 64'd7 : 64'd3);
    check("R8 jal link", mem[140], 64'd100);
    check("R8 jal skips", mem[141], 64'd0);
    check("R8 jalr link", mem[142], 64'd120);
    check("R8 jalr bit0 cleared target", mem[143], 64'd0);
    check("R9 result to a0", mem[144], sysRet);
    check("R9 one ecall served", 64'(ecallSeen), 64'd1);
    check("R3 ld loaded operand", mem[128], a);
  endtask

  initial begin
    logic [63:0] a, b;
    int n;
    void'($urandom(32'd1234));
    for (int r = 0; r < 12; r++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case (r)
        0: b = 64'd0;
        1: b = a;
        2: begin a = 64'd5; b = {64{1'b1}}; end
        3: begin a = {64{1'b1}}; b = 64'd3; end
        4: begin a = 64'd0; b = 64'd0; end
        default: ;
      endcase
      mainRound(a, b);
    end

    // R4: misaligned store writes nothing and halts
    clearMem();
    mem[127] = 64'h1234_5678_9ABC_DEF0;
    sysExpected = 1'b0;
    put(encI(1, 0, 0, 5, 7'b0010011));
    put(encS(12'h3FC, 5, 0));
    put(32'h0000_0073);
    runUntilHalt("misaligned sd");
    check("R4 misaligned store discarded", mem[127], 64'h1234_5678_9ABC_DEF0);

    // R4: misaligned load halts before any ecall
    clearMem();
    put(encI(12'h401, 0, 3, 6, 7'b0000011));
    put(32'h0000_0073);
    runUntilHalt("misaligned ld");

    // R1: a near-miss ecall encoding is illegal
    clearMem();
    put(32'h0010_0073);
    put(32'h0000_0073);
    runUntilHalt("bad system word");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // global watchdog
  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule